// File: doc/BRIEF.md
# Oscillator Range Control Register

This block is the 8-bit control and status register that sets the operating range of a frequency-locked-loop clock generator. Software writes a 2-bit range select and a 1-bit fine-tune flag. The block turns those two fields into the FLL multiplication factor that the loop uses. It also returns, through the register's readback, the range that the oscillator domain has actually applied.

The range select enters the oscillator clock domain through a two-flop synchronizer and is presented there as the applied range. That applied value returns to the bus domain through a second two-flop synchronizer and becomes the status field. The status field therefore lags a write by several bus cycles. In the four bypass and PLL clock modes the status field reads zero. Range writes are refused while the low-power qualifier or the PLL-select qualifier is set.

Top module: `osc_range_ctl`

## Requirements
- R1: After reset, `range_sel` is 00, `fine_tune` is 0, `rd_data` is 0x00 and `fll_factor` is 512.
- R2: A cycle with `wr_en` high and both `lp_mode` and `pll_sel` low loads `wr_data[7:6]` into `range_sel`. The new value is visible after that clock edge.
- R3: While `lp_mode` or `pll_sel` is high, a write leaves `range_sel` unchanged.
- R4: A cycle with `wr_en` high always loads `wr_data[5]` into `fine_tune`, whatever the qualifiers are.
- R5: `rd_data[4:0]` always reads zero and `rd_data[5]` reads `fine_tune`. Writes to bits 4:0 have no effect.
- R6: With `fine_tune` at 0, `fll_factor` is 512 when `range_sel` is 00 and 1024 when it is 01. With `fine_tune` at 1, the values are 608 and 1216.
- R7: `range_sel` values 10 and 11 are stored as written and yield the same factor as 01.
- R8: On the first bus cycle after an accepted write, `rd_data[7:6]` still shows the previously applied range.
- R9: `range_osc` follows `range_sel` after two oscillator-clock edges. Within 12 bus cycles of a write, `rd_data[7:6]` equals the written range. This holds while the oscillator clock runs no slower than half the bus clock.
- R10: When `clk_mode` is 100, 101, 110 or 111, `rd_data[7:6]` reads 00 in the same cycle, whatever the range. For codes 000 to 011 it shows the synchronized range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| osc_clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| lp_mode | input | 1 | Low-power qualifier; blocks range writes |
| pll_sel | input | 1 | PLL-select qualifier; blocks range writes |
| clk_mode | input | 3 | Clock-mode code; 100 to 111 force the status to zero |
| rd_data | output | 8 | Register readback: status[7:6], fine-tune[5], zeros[4:0] |
| range_sel | output | 2 | Stored range select (bus domain) |
| fine_tune | output | 1 | Stored fine-tune flag |
| range_osc | output | 2 | Range applied in the oscillator domain |
| fll_factor | output | 11 | FLL multiplication factor |

## Verification
The bench drives inputs and samples outputs on the falling edge of the bus clock. Register fields and `fll_factor` are due one bus cycle after the write strobe, so they are read at the falling edge that follows the write. The status field is checked at that same falling edge for its old value. It is checked again after a 12-cycle settling wait for the new value, and `range_osc` is compared at that point as well. Forcing by the clock mode is combinational, so each of the eight codes is applied and read back within a single bus cycle.

// File: rtl/osc_range_pkg.sv
package osc_range_pkg;
  localparam int RANGE_W  = 2;
  localparam int FACTOR_W = 11;
  localparam int MODE_W   = 3;

  typedef logic [RANGE_W-1:0]  range_t;
  typedef logic [FACTOR_W-1:0] factor_t;

  // Multiplication factor for a stored range and fine-tune flag.
  // Any non-zero range behaves as mid range.
  function automatic factor_t range_factor(range_t rng, logic tune);
    logic low;
    low = (rng == '0);
    case ({tune, low})
      2'b01:   return factor_t'(512);
      2'b00:   return factor_t'(1024);
      2'b11:   return factor_t'(608);
      default: return factor_t'(1216);
    endcase
  endfunction

  // Bypass and PLL clock modes hide the applied range.
  function automatic logic mode_hides_status(logic [MODE_W-1:0] mode);
    case (mode)
      3'b100, 3'b101, 3'b110, 3'b111: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/osc_range_sync.sv
module osc_range_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= (s == 0) ? d : stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/osc_range_regs.sv
module osc_range_regs
  import osc_range_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  range_t wr_range,
  input  logic   wr_tune,
  input  logic   lp_mode,
  input  logic   pll_sel,
  output range_t range_q,
  output logic   tune_q,
  output logic   range_wr_ok
);
  assign range_wr_ok = wr_en && !lp_mode && !pll_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      range_q <= '0;
      tune_q  <= 1'b0;
    end else begin
      if (range_wr_ok) range_q <= wr_range;
      if (wr_en)       tune_q  <= wr_tune;
    end
  end

  a_r2_range_load: assert property (@(posedge clk) disable iff (!rst_n)
    range_wr_ok |=> range_q == $past(wr_range));
  a_r3_range_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (lp_mode || pll_sel)) |=> $stable(range_q));
  a_r4_tune_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tune_q == $past(wr_tune));
  a_r4_tune_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(tune_q));
endmodule

// File: rtl/osc_range_ctl.sv
module osc_range_ctl
  import osc_range_pkg::*;
(
  input  logic                clk,
  input  logic                osc_clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  input  logic                lp_mode,
  input  logic                pll_sel,
  input  logic [MODE_W-1:0]   clk_mode,
  output logic [7:0]          rd_data,
  output logic [RANGE_W-1:0]  range_sel,
  output logic                fine_tune,
  output logic [RANGE_W-1:0]  range_osc,
  output logic [FACTOR_W-1:0] fll_factor
);
  localparam int SYNC_STAGES = 2;

  range_t range_q;
  range_t status_sync;
  logic   tune_q;
  logic   range_wr_ok;
  logic   status_hidden;
  range_t status_field;

  osc_range_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_range    (wr_data[7:6]),
    .wr_tune     (wr_data[5]),
    .lp_mode     (lp_mode),
    .pll_sel     (pll_sel),
    .range_q     (range_q),
    .tune_q      (tune_q),
    .range_wr_ok (range_wr_ok)
  );

  // bus -> oscillator domain
  osc_range_sync #(.WIDTH(RANGE_W), .STAGES(SYNC_STAGES)) u_to_osc (
    .clk   (osc_clk),
    .rst_n (rst_n),
    .d     (range_q),
    .q     (range_osc)
  );

  // oscillator -> bus domain
  osc_range_sync #(.WIDTH(RANGE_W), .STAGES(SYNC_STAGES)) u_to_bus (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (range_osc),
    .q     (status_sync)
  );

  assign status_hidden = mode_hides_status(clk_mode);
  assign status_field  = status_hidden ? '0 : status_sync;

  assign range_sel  = range_q;
  assign fine_tune  = tune_q;
  assign fll_factor = range_factor(range_q, tune_q);
  assign rd_data    = {status_field, tune_q, 5'b0_0000};

  always_comb begin
    if (rst_n) begin
      a_r5_low_bits_zero: assert (rd_data[4:0] == 5'd0 && rd_data[5] == fine_tune);
      a_r10_status_hidden: assert (!clk_mode[2] || rd_data[7:6] == 2'b00);
      a_r6_factor_legal: assert (fll_factor == 11'd512 || fll_factor == 11'd608 ||
                                 fll_factor == 11'd1024 || fll_factor == 11'd1216);
    end
  end

  a_r8_status_lags: assert property (@(posedge clk) disable iff (!rst_n)
    range_wr_ok |=> (status_sync == $past(status_sync) || status_sync == $past(range_osc)));
endmodule

// File: tb/osc_range_ctl_bench.sv
module osc_range_ctl_bench;
  logic        clk = 0, osc_clk = 0, rst_n = 0;
  logic        wr_en = 0, lp_mode = 0, pll_sel = 0;
  logic [7:0]  wr_data = 0;
  logic [2:0]  clk_mode = 0;
  logic [7:0]  rd_data;
  logic [1:0]  range_sel, range_osc;
  logic        fine_tune;
  logic [10:0] fll_factor;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always #3.5 osc_clk = ~osc_clk;

  osc_range_ctl u_osc_range_ctl (
    .clk(clk), .osc_clk(osc_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .lp_mode(lp_mode), .pll_sel(pll_sel), .clk_mode(clk_mode), .rd_data(rd_data),
    .range_sel(range_sel), .fine_tune(fine_tune), .range_osc(range_osc),
    .fll_factor(fll_factor));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_factor(input int rng, input int ft);
    int base;
    base = (rng == 0) ? 512 : 1024;
    return ft ? base * 19 / 16 : base;
  endfunction

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = ~d;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 range_sel", range_sel, 0);
    check("R1 fine_tune", fine_tune, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 factor", fll_factor, 512);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R4 R5 R6 R7 exhaustive write sweep with qualifiers low
    for (int d = 0; d < 256; d++) begin
      do_write(8'(d));
      check("R2 range_sel", range_sel, d >> 6);
      check("R4 fine_tune", fine_tune, (d >> 5) & 1);
      check("R5 rd_data[5:0]", rd_data[5:0], ((d >> 5) & 1) << 5);
      check("R6 R7 factor", fll_factor, exp_factor(d >> 6, (d >> 5) & 1));
    end

    // R3 gated range writes, R4 fine-tune still writes
    do_write(8'h40);
    for (int q = 1; q < 4; q++) begin
      for (int d = 0; d < 256; d += 32) begin
        lp_mode = q[0]; pll_sel = q[1];
        do_write(8'(d));
        check("R3 range_sel held", range_sel, 1);
        check("R4 fine_tune gated", fine_tune, (d >> 5) & 1);
        check("R3 factor", fll_factor, exp_factor(1, (d >> 5) & 1));
      end
    end
    lp_mode = 0; pll_sel = 0;

    // R8 R9 R10 status path
    do_write(8'h00);
    settle();
    for (int r = 1; r < 8; r++) begin
      int prev, nxt;
      prev = (r - 1) & 3;
      nxt  = r & 3;
      clk_mode = 3'b000;
      do_write(8'(nxt << 6));
      check("R8 status old", rd_data[7:6], prev);
      settle();
      check("R9 range_osc", range_osc, nxt);
      for (int m = 0; m < 8; m++) begin
        @(negedge clk); clk_mode = 3'(m); #1;
        check("R10 status by mode", rd_data[7:6], (m >= 4) ? 0 : nxt);
      end
      clk_mode = 3'b000;
      @(negedge clk);
      check("R9 status new", rd_data[7:6], nxt);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule